// File: doc/BRIEF.md
# Three-Semaphore Privilege Ping-Pong Controller

This block runs on one side of a shared buffer. It hands a single access privilege back and forth between two agents. It uses only three hardware semaphores, called A, B and C, which live in a shared semaphore unit outside the block. An agent holds the privilege while it owns exactly two of the three semaphores, and it keeps the privilege for as long as it likes. The block asks the semaphore unit to take or give back one semaphore at a time. Each request uses a simple handshake: the request is held, and the unit answers with a one-cycle grant or a one-cycle deny.

When the local side asks to hand the privilege over, the controller gives back the semaphore it has owned the longest. It then keeps asking for the semaphore that follows its newest one in the cycle A, B, C, A. When that request is granted it owns two semaphores again, and so it holds the privilege once more. Every state has one legal successor. No shared status word is kept in memory, and correctness does not depend on timing.

At power-up each agent claims its starting semaphores. The initial owner claims A and then B, and the other agent claims C. Both then wait a fixed settle interval before the exchange begins. The role is chosen by a parameter, so two copies of the block, one of each role, form a complete pair.

Top module: `pingpong_sem_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after any clock edge that samples it high, the controller owns no semaphore, `privilege` is low and `semReq` is low.
- R2: In the cycle after reset is released, the initial owner requests a take of A (semIdx 0, semFree 0). Once A is granted it requests B (semIdx 1). The other agent requests C (semIdx 2).
- R3: Once the last start-up take is granted, `semReq` stays low for exactly SETTLE_CYCLES cycles. After that the initial owner holds the privilege, and the other agent starts requesting the semaphore that follows C.
- R4: `privilege` is high exactly when `ownMask` has two bits set (bit 0 is A, bit 1 is B, bit 2 is C). `ownMask` and `privilege` change in the cycle after the clock edge that samples a grant.
- R5: A `passCmd` sampled while the privilege is held and the settle interval is over produces, in the next cycle, a release request (semFree 1) for the semaphore owned the longest. A `passCmd` at any other time has no effect.
- R6: After a release is granted, the controller requests a take of the semaphore that follows its remaining one in the cycle A→B→C→A. It never requests a semaphore it already owns.
- R7: After a deny on a take, `semReq` stays low for exactly RETRY_GAP cycles. The same take is then requested again.
- R8: While a request is pending, `semReq`, `semFree` and `semIdx` hold steady until a grant arrives. A release request that is denied stays pending.
- R9: After start-up, granted operations strictly alternate between release and take. A take is never granted for the semaphore that was just released.
- R10: After six handovers, three by each agent, the initial owner owns A and B again and the other agent owns C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| passCmd | input | 1 | Local request to hand the privilege to the other agent |
| semReq | output | 1 | A request to the semaphore unit is pending |
| semFree | output | 1 | 1 = release request, 0 = take request |
| semIdx | output | 2 | Target semaphore: 0 = A, 1 = B, 2 = C |
| semGrant | input | 1 | One-cycle grant from the semaphore unit |
| semDeny | input | 1 | One-cycle deny from the semaphore unit |
| ownMask | output | 3 | Semaphores currently owned, bit n is semaphore n |
| privilege | output | 1 | High while two semaphores are owned |

## Verification
Every result is registered once. A grant or deny sampled at an edge is visible in `ownMask`, `privilege` and the request outputs just after that edge. A pass sampled at an edge raises the release request in the next cycle. A deny pushes the next attempt back by exactly RETRY_GAP cycles, and the last start-up grant is followed by exactly SETTLE_CYCLES quiet cycles. The bench pairs an initial-owner copy and a non-owner copy around a behavioural semaphore unit. It steps a per-agent reference model on each rising edge and compares all outputs on the falling edge of the same cycle, so each expected value is checked in the exact cycle it is due.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

  localparam logic [1:0] SEM_A = 2'd0;
  localparam logic [1:0] SEM_B = 2'd1;
  localparam logic [1:0] SEM_C = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOOT_GET,
    ST_BOOT_GAP,
    ST_SETTLE,
    ST_HOLD,
    ST_FREE,
    ST_GET,
    ST_GAP
  } ctrlState_t;

  typedef struct packed {
    logic       take;
    logic       drop;
    logic [1:0] sel;
    logic       loadGap;
    logic       loadSettle;
  } dpStrobe_t;

  function automatic logic [1:0] semAfter(input logic [1:0] s);
    case (s)
      SEM_A:   semAfter = SEM_B;
      SEM_B:   semAfter = SEM_C;
      default: semAfter = SEM_A;
    endcase
  endfunction

  function automatic logic [2:0] semBit(input logic [1:0] s);
    semBit = 3'b001 << s;
  endfunction

endpackage

// File: rtl/pingpong_own_dp.sv
module pingpong_own_dp
  import pingpong_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int RETRY_GAP     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  dpStrobe_t  strobe,
  output logic [2:0] ownMask,
  output logic [1:0] oldestIdx,
  output logic [1:0] newestIdx,
  output logic       waitDone
);

  localparam int MAX_WAIT = (SETTLE_CYCLES > RETRY_GAP) ? SETTLE_CYCLES : RETRY_GAP;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD    = CNT_W'(RETRY_GAP - 1);

  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ownMask   <= '0;
      oldestIdx <= SEM_A;
      newestIdx <= SEM_A;
      waitCnt   <= '0;
    end else begin
      if (strobe.take) begin
        ownMask <= ownMask | semBit(strobe.sel);
        if (ownMask == '0) oldestIdx <= strobe.sel;
        newestIdx <= strobe.sel;
      end else if (strobe.drop) begin
        ownMask   <= ownMask & ~semBit(oldestIdx);
        oldestIdx <= newestIdx;
      end
      if (strobe.loadSettle)   waitCnt <= SETTLE_LOAD;
      else if (strobe.loadGap) waitCnt <= GAP_LOAD;
      else if (waitCnt != '0)  waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitDone = (waitCnt == '0);

  // R4: never more than two semaphores at once
  assert_mask_limit_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(ownMask) <= 2);

  // R5: a release always targets a semaphore that is really held
  assert_drop_owned_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.drop |-> (ownMask & semBit(oldestIdx)) != 3'b000);

endmodule

// File: rtl/pingpong_ctrl_fsm.sv
module pingpong_ctrl_fsm
  import pingpong_pkg::*;
#(
  parameter bit INIT_OWNER = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       passCmd,
  input  logic       semGrant,
  input  logic       semDeny,
  input  logic [2:0] ownMask,
  input  logic [1:0] oldestIdx,
  input  logic [1:0] newestIdx,
  input  logic       waitDone,
  output logic       semReq,
  output logic       semFree,
  output logic [1:0] semIdx,
  output dpStrobe_t  strobe
);

  ctrlState_t state, stateNext;
  logic [1:0] bootIdx;
  logic       bootLast;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    if (INIT_OWNER) begin
      bootIdx  = ownMask[SEM_A] ? SEM_B : SEM_A;
      bootLast = ownMask[SEM_A];
    end else begin
      bootIdx  = SEM_C;
      bootLast = 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    semReq    = 1'b0;
    semFree   = 1'b0;
    semIdx    = SEM_A;
    strobe    = '0;
    case (state)
      ST_IDLE: stateNext = ST_BOOT_GET;
      ST_BOOT_GET: begin
        semReq = 1'b1;
        semIdx = bootIdx;
        if (semGrant) begin
          strobe.take = 1'b1;
          strobe.sel  = bootIdx;
          if (bootLast) begin
            strobe.loadSettle = 1'b1;
            stateNext = ST_SETTLE;
          end
        end else if (semDeny) begin
          strobe.loadGap = 1'b1;
          stateNext = ST_BOOT_GAP;
        end
      end
      ST_BOOT_GAP: if (waitDone) stateNext = ST_BOOT_GET;
      ST_SETTLE:   if (waitDone) stateNext = INIT_OWNER ? ST_HOLD : ST_GET;
      ST_HOLD:     if (passCmd)  stateNext = ST_FREE;
      ST_FREE: begin
        semReq  = 1'b1;
        semFree = 1'b1;
        semIdx  = oldestIdx;
        if (semGrant) begin
          strobe.drop = 1'b1;
          stateNext = ST_GET;
        end
      end
      ST_GET: begin
        semReq = 1'b1;
        semIdx = semAfter(newestIdx);
        if (semGrant) begin
          strobe.take = 1'b1;
          strobe.sel  = semAfter(newestIdx);
          stateNext = ST_HOLD;
        end else if (semDeny) begin
          strobe.loadGap = 1'b1;
          stateNext = ST_GAP;
        end
      end
      ST_GAP:  if (waitDone) stateNext = ST_GET;
      default: stateNext = ST_IDLE;
    endcase
  end

  // R1: reset leaves nothing owned and nothing requested
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!semReq && ownMask == 3'b000));

  // R8: a pending request holds its operation and target
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (semReq && !semGrant && !semDeny) |=> (semReq && $stable(semIdx) && $stable(semFree)));

  // R6: a take never targets a semaphore already held
  assert_get_unowned_R6: assert property (@(posedge clk) disable iff (rst)
    (semReq && !semFree) |-> (ownMask & semBit(semIdx)) == 3'b000);

  // R7: a denied take is followed by a quiet cycle
  assert_deny_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (semReq && !semFree && semDeny) |=> !semReq);

  // R9: a granted release leaves exactly one semaphore held
  assert_free_single_R9: assert property (@(posedge clk) disable iff (rst)
    (semReq && semFree && semGrant) |=> $countones(ownMask) == 1);

  // R4: a granted take while running restores the pair
  assert_get_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GET && semGrant) |=> $countones(ownMask) == 2);

endmodule

// File: rtl/pingpong_sem_ctrl.sv
module pingpong_sem_ctrl
  import pingpong_pkg::*;
#(
  parameter bit INIT_OWNER    = 1'b1,
  parameter int SETTLE_CYCLES = 16,
  parameter int RETRY_GAP     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       passCmd,
  output logic       semReq,
  output logic       semFree,
  output logic [1:0] semIdx,
  input  logic       semGrant,
  input  logic       semDeny,
  output logic [2:0] ownMask,
  output logic       privilege
);

  dpStrobe_t  strobe;
  logic [1:0] oldestIdx;
  logic [1:0] newestIdx;
  logic       waitDone;

  pingpong_ctrl_fsm #(.INIT_OWNER(INIT_OWNER)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .passCmd   (passCmd),
    .semGrant  (semGrant),
    .semDeny   (semDeny),
    .ownMask   (ownMask),
    .oldestIdx (oldestIdx),
    .newestIdx (newestIdx),
    .waitDone  (waitDone),
    .semReq    (semReq),
    .semFree   (semFree),
    .semIdx    (semIdx),
    .strobe    (strobe)
  );

  pingpong_own_dp #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .RETRY_GAP     (RETRY_GAP)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .ownMask   (ownMask),
    .oldestIdx (oldestIdx),
    .newestIdx (newestIdx),
    .waitDone  (waitDone)
  );

  assign privilege = (ownMask[0] & ownMask[1]) | (ownMask[1] & ownMask[2]) |
                     (ownMask[0] & ownMask[2]);

endmodule

// File: tb/pingpong_sem_ctrl_tb.sv
`timescale 1ns/1ps
module pingpong_sem_ctrl_tb;

  localparam int SETTLE = 8;
  localparam int GAP    = 3;
  localparam int P_BOOT = 0, P_BGAP = 1, P_SETTLE = 2, P_HOLD = 3,
                 P_FREE = 4, P_GET = 5, P_GAP = 6, P_IDLE = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pass    [2];
  logic sReq    [2];
  logic sFree   [2];
  logic [1:0] sIdx [2];
  logic grant   [2];
  logic deny    [2];
  logic [2:0] mask [2];
  logic priv    [2];
  logic [2:0] busy;

  int nChecks = 0;
  int nFail   = 0;
  bit started = 0;
  bit finished = 0;

  int ph[2], cnt[2], nOwn[2], oldI[2], newI[2], maskM[2], lastOp[2], lastFreed[2];

  always #5 clk = ~clk;

  pingpong_sem_ctrl #(.INIT_OWNER(1'b1), .SETTLE_CYCLES(SETTLE), .RETRY_GAP(GAP)) u_dut (
    .clk(clk), .rst(rst), .passCmd(pass[0]), .semReq(sReq[0]), .semFree(sFree[0]),
    .semIdx(sIdx[0]), .semGrant(grant[0]), .semDeny(deny[0]), .ownMask(mask[0]),
    .privilege(priv[0]));

  pingpong_sem_ctrl #(.INIT_OWNER(1'b0), .SETTLE_CYCLES(SETTLE), .RETRY_GAP(GAP)) u_peer (
    .clk(clk), .rst(rst), .passCmd(pass[1]), .semReq(sReq[1]), .semFree(sFree[1]),
    .semIdx(sIdx[1]), .semGrant(grant[1]), .semDeny(deny[1]), .ownMask(mask[1]),
    .privilege(priv[1]));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural semaphore unit: releases always granted, takes granted when free,
  // agent 0 wins a same-cycle clash
  always_comb begin
    for (int a = 0; a < 2; a++) begin
      grant[a] = 1'b0;
      deny[a]  = 1'b0;
      if (sReq[a] === 1'b1) begin
        if (sFree[a]) grant[a] = 1'b1;
        else if (busy[sIdx[a]]) deny[a] = 1'b1;
        else if (a == 1 && sReq[0] === 1'b1 && !sFree[0] && sIdx[0] == sIdx[1]) deny[a] = 1'b1;
        else grant[a] = 1'b1;
      end
    end
  end

  function automatic int expReq(int a);
    return (ph[a] == P_BOOT || ph[a] == P_FREE || ph[a] == P_GET) ? 1 : 0;
  endfunction

  function automatic int expIdx(int a);
    case (ph[a])
      P_BOOT:  return (a == 0) ? (((maskM[a] & 1) != 0) ? 1 : 0) : 2;
      P_FREE:  return oldI[a];
      P_GET:   return (newI[a] + 1) % 3;
      default: return 0;
    endcase
  endfunction

  function automatic string reqTag(int p);
    case (p)
      P_BOOT:         return "R2";
      P_SETTLE:       return "R3";
      P_HOLD:         return "R5";
      P_BGAP, P_GAP:  return "R7";
      P_IDLE:         return "R1";
      default:        return "R8";
    endcase
  endfunction

  function automatic string selTag(int p);
    case (p)
      P_BOOT:  return "R2";
      P_FREE:  return "R5";
      default: return "R6";
    endcase
  endfunction

  // reference model, stepped on every rising edge
  always @(posedge clk) begin
    bit g [2];
    bit d [2];
    bit f [2];
    int ix [2];
    started = 1;
    for (int a = 0; a < 2; a++) begin
      g[a] = grant[a]; d[a] = deny[a]; f[a] = sFree[a]; ix[a] = int'(sIdx[a]);
    end
    if (rst) begin
      busy = 3'b000;
      for (int a = 0; a < 2; a++) begin
        ph[a] = P_IDLE; cnt[a] = 0; nOwn[a] = 0; oldI[a] = 0; newI[a] = 0;
        maskM[a] = 0; lastOp[a] = -1; lastFreed[a] = -1;
      end
    end else begin
      for (int a = 0; a < 2; a++) begin
        case (ph[a])
          P_IDLE: ph[a] = P_BOOT;
          P_BOOT: begin
            if (g[a]) begin
              if (nOwn[a] == 0) oldI[a] = ix[a];
              newI[a] = ix[a]; maskM[a] |= (1 << ix[a]); nOwn[a]++;
              if (nOwn[a] == ((a == 0) ? 2 : 1)) begin ph[a] = P_SETTLE; cnt[a] = SETTLE; end
            end else if (d[a]) begin ph[a] = P_BGAP; cnt[a] = GAP; end
          end
          P_BGAP, P_GAP: begin
            cnt[a]--;
            if (cnt[a] == 0) ph[a] = (ph[a] == P_BGAP) ? P_BOOT : P_GET;
          end
          P_SETTLE: begin
            cnt[a]--;
            if (cnt[a] == 0) ph[a] = (nOwn[a] == 2) ? P_HOLD : P_GET;
          end
          P_HOLD: if (pass[a]) ph[a] = P_FREE;
          P_FREE: if (g[a]) begin
            check(lastOp[a] != 1, "R9", lastOp[a], 0);
            lastOp[a] = 1; lastFreed[a] = oldI[a];
            maskM[a] &= ~(1 << oldI[a]); oldI[a] = newI[a]; nOwn[a]--;
            ph[a] = P_GET;
          end
          P_GET: begin
            if (g[a]) begin
              check(lastOp[a] != 0, "R9", lastOp[a], 1);
              check(ix[a] != lastFreed[a], "R9", ix[a], (lastFreed[a] + 1) % 3);
              lastOp[a] = 0;
              newI[a] = ix[a]; maskM[a] |= (1 << ix[a]); nOwn[a]++;
              ph[a] = P_HOLD;
            end else if (d[a]) begin ph[a] = P_GAP; cnt[a] = GAP; end
          end
          default: ;
        endcase
      end
      for (int a = 0; a < 2; a++)
        if (g[a]) busy[ix[a]] = f[a] ? 1'b0 : 1'b1;
    end
  end

  // compare every output on the falling edge
  always @(negedge clk) begin
    if (started && !finished) begin
      for (int a = 0; a < 2; a++) begin
        check(sReq[a] === 1'(expReq(a)), reqTag(ph[a]), int'(sReq[a]), expReq(a));
        if (expReq(a) == 1) begin
          check(sFree[a] === (ph[a] == P_FREE), selTag(ph[a]), int'(sFree[a]), int'(ph[a] == P_FREE));
          check(sIdx[a] === 2'(expIdx(a)), selTag(ph[a]), int'(sIdx[a]), expIdx(a));
        end
        check(mask[a] === 3'(maskM[a]), "R4", int'(mask[a]), maskM[a]);
        check(priv[a] === (nOwn[a] == 2), "R4", int'(priv[a]), int'(nOwn[a] == 2));
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulsePass(input int a);
    pass[a] = 1'b1;
    cycles(1);
    pass[a] = 1'b0;
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", 20000, 0);
    summary();
  end

  initial begin
    pass[0] = 1'b0;
    pass[1] = 1'b0;
    rst = 1'b1;
    cycles(3);
    // R1: quiet during reset
    for (int a = 0; a < 2; a++) begin
      check(mask[a] == 3'b000, "R1", int'(mask[a]), 0);
      check(priv[a] == 1'b0, "R1", int'(priv[a]), 0);
      check(sReq[a] == 1'b0, "R1", int'(sReq[a]), 0);
    end
    rst = 1'b0;
    cycles(16);
    // R2/R3: start-up claims settled
    check(mask[0] == 3'b011, "R2", int'(mask[0]), 3);
    check(mask[1] == 3'b100, "R2", int'(mask[1]), 4);
    check(priv[0] == 1'b1, "R3", int'(priv[0]), 1);
    // R5: pass without privilege has no effect
    pulsePass(1);
    cycles(5);
    check(mask[1] == 3'b100, "R5", int'(mask[1]), 4);
    check(!(sReq[1] && sFree[1]), "R5", int'(sFree[1]), 0);
    // six handovers
    for (int k = 0; k < 6; k++) begin
      pulsePass(k % 2);
      cycles(12);
      check(priv[(k + 1) % 2] == 1'b1, "R6", int'(priv[(k + 1) % 2]), 1);
      check(priv[k % 2] == 1'b0, "R6", int'(priv[k % 2]), 0);
    end
    // R10: ownership back to start-up layout
    check(mask[0] == 3'b011, "R10", int'(mask[0]), 3);
    check(mask[1] == 3'b100, "R10", int'(mask[1]), 4);
    // reset in the middle of the exchange
    pulsePass(0);
    cycles(1);
    rst = 1'b1;
    cycles(2);
    check(mask[0] == 3'b000 && mask[1] == 3'b000, "R1", int'(mask[0]), 0);
    rst = 1'b0;
    cycles(4);
    // R5: pass during settle is ignored
    pulsePass(0);
    cycles(12);
    check(mask[0] == 3'b011, "R5", int'(mask[0]), 3);
    check(priv[0] == 1'b1, "R5", int'(priv[0]), 1);
    pulsePass(0);
    cycles(12);
    check(priv[1] == 1'b1, "R6", int'(priv[1]), 1);
    check(mask[1] == 3'b101, "R6", int'(mask[1]), 5);
    summary();
  end

endmodule